// File: doc/BRIEF.md
# Disk Head Step Pulse Sequencer

This block moves the read/write heads of a stepper-driven hard drive. A command either gives a signed track offset or asks for a return to track zero. For an offset command the block first sets the direction line. It then holds that line steady for a settle interval. After that it produces as many step pulses as the offset's magnitude. The pulse width and the spacing between pulses come from one of two timing profiles. The fast profile suits drives that buffer their steps. The slow profile suits drives that do not.

When the last pulse and its trailing spacing are done, the sequencer asks an external ready qualifier whether the drive has finished seeking. It does this with a request/acknowledge handshake. It then posts an OK or ready-error status. A return-to-zero command always steps inward at the slow pulse width, one step at a time. After each step it waits for a full ready check and then looks at the active-low track-zero input again. All timing is counted in cycles of the block clock. The defaults assume a 200 MHz clock, where one count is 5 ns.

Top module: `head_step_seq`

## Requirements
- R1: While reset is held, and after it is released until a command arrives, busy, step_o, rdy_req and done are 0, dir_n_o is 1 and done_status is 2'b00.
- R2: A command is taken when cmd_valid is 1 and busy is 0. From the next cycle busy stays 1 until the done cycle. A cmd_valid seen while busy is 1 changes neither the pulse count nor the direction of the command in progress.
- R3: dir_n_o goes to 0 (inward) for a negative two's-complement offset or for a return-to-zero command. It goes to 1 (outward) for an offset of zero or more. It does not change while step_o is 1.
- R4: For an offset command, dir_n_o is stable for SETTLE cycles before the first step pulse rises.
- R5: An offset command produces exactly |cmd_offset| step pulses. An offset of zero produces none but still performs the ready check. The most negative offset produces 2^(OFS_W-1) pulses.
- R6: With cmd_slow = 0, each pulse is FAST_PW cycles high and consecutive pulses are FAST_GAP low cycles apart.
- R7: With cmd_slow = 1, each pulse is SLOW_PW cycles high and consecutive pulses are SLOW_GAP low cycles apart.
- R8: rdy_req rises only after the last pulse's full trailing gap, or after the settle time when there are no pulses. It stays 1 until rdy_ack is seen. An offset command makes exactly one request.
- R9: done is 1 for exactly one cycle, and busy falls on the cycle after it. done_status is 2'b01 when rdy_ok was 1 with the final acknowledge, and 2'b10 when it was 0.
- R10: A return-to-zero command (cmd_recal = 1) ends with 2'b01 and no pulse if trk0_n is 0 after the settle time. Otherwise it gives one SLOW_PW pulse, a ready check, and then looks at trk0_n again, repeating until trk0_n is 0.
- R11: During return-to-zero, a ready check acknowledged with rdy_ok = 0 ends the command at once with status 2'b10 and no more pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_recal | input | 1 | 1 = return to track zero; offset and mode are ignored |
| cmd_slow | input | 1 | 1 = slow timing profile, 0 = fast |
| cmd_offset | input | OFS_W | Signed two's-complement track offset; negative means inward |
| rdy_ack | input | 1 | Ready qualifier has a result |
| rdy_ok | input | 1 | Result of the ready check, valid with rdy_ack |
| trk0_n | input | 1 | Track-zero indication, active low |
| step_o | output | 1 | Step pulse, active high |
| dir_n_o | output | 1 | Direction, 0 = inward, 1 = outward |
| rdy_req | output | 1 | Ready check request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| done_status | output | 2 | 00 none, 01 OK, 10 ready error |

## Verification
The checker watches several rules on every cycle. It checks that direction never moves while a pulse is high. It checks that no pulse is shorter than the shorter profile width and that no pulse appears while idle or during a ready request. It also checks that a request is held until acknowledged and that done lasts one cycle and ends busy.

Some properties only the bench scenarios can show. These are exact pulse counts, the settle time, the gap length of each profile, and the trailing gap before the request. The same holds for the return-to-zero loop against a modelled head position, for a ready failure in the middle of that loop, and for a command that is ignored while busy.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_PULSE,
    S_GAP,
    S_READY,
    S_TRK,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    STAT_NONE    = 2'b00,
    STAT_OK      = 2'b01,
    STAT_RDY_ERR = 2'b10
  } seq_status_e;

endpackage

// File: rtl/stepseq_timer.sv
// Loadable down-counter: a load of N keeps expired low for N-1 cycles,
// so a state that loads it on entry lasts exactly N cycles.
module stepseq_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val - CNT_W'(1);
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/stepseq_stepcnt.sv
// Converts the signed offset into a pulse count and counts it down.
module stepseq_stepcnt #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] offset,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_last
);

  logic [OFS_W-1:0] mag_q;
  logic [OFS_W-1:0] mag_d;
  logic             mag_en;

  always_comb begin
    mag_en = load || dec;
    if (load) mag_d = offset[OFS_W-1] ? (~offset + OFS_W'(1)) : offset;
    else      mag_d = mag_q - OFS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mag_q <= '0;
    else if (mag_en) mag_q <= mag_d;
  end

  assign is_zero = (mag_q == '0);
  assign is_last = (mag_q == OFS_W'(1));

endmodule

// File: rtl/stepseq_fsm.sv
module stepseq_fsm
  import stepseq_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int FAST_PW  = 1000,
  parameter int FAST_GAP = 6000,
  parameter int SLOW_PW  = 8000,
  parameter int SLOW_GAP = 800000,
  parameter int SETTLE   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_recal,
  input  logic             cmd_slow,
  input  logic             ofs_neg,
  input  logic             cnt_zero,
  input  logic             cnt_last,
  input  logic             tmr_expired,
  input  logic             rdy_ack,
  input  logic             rdy_ok,
  input  logic             trk0_n,
  output logic             cnt_load,
  output logic             cnt_dec,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             step_o,
  output logic             dir_n_o,
  output logic             rdy_req,
  output logic             busy,
  output logic             done,
  output logic [1:0]       done_status
);

  localparam logic [CNT_W-1:0] FAST_PW_V  = CNT_W'(FAST_PW);
  localparam logic [CNT_W-1:0] FAST_GAP_V = CNT_W'(FAST_GAP);
  localparam logic [CNT_W-1:0] SLOW_PW_V  = CNT_W'(SLOW_PW);
  localparam logic [CNT_W-1:0] SLOW_GAP_V = CNT_W'(SLOW_GAP);
  localparam logic [CNT_W-1:0] SETTLE_V   = CNT_W'(SETTLE);

  seq_state_e  state_q, state_d;
  seq_status_e stat_q, stat_d;
  logic        dir_n_q, slow_q, recal_q;
  logic        accept;
  logic [CNT_W-1:0] pw_sel, gap_sel;

  assign pw_sel  = slow_q ? SLOW_PW_V  : FAST_PW_V;
  assign gap_sel = slow_q ? SLOW_GAP_V : FAST_GAP_V;

  always_comb begin
    state_d  = state_q;
    stat_d   = stat_q;
    accept   = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = SETTLE_V;
    case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_V;
          stat_d   = STAT_NONE;
          state_d  = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (tmr_expired) begin
          if (recal_q)       state_d = S_TRK;
          else if (cnt_zero) state_d = S_READY;
          else begin
            tmr_load = 1'b1;
            tmr_val  = pw_sel;
            state_d  = S_PULSE;
          end
        end
      end
      S_PULSE: begin
        if (tmr_expired) begin
          if (recal_q) state_d = S_READY;
          else begin
            tmr_load = 1'b1;
            tmr_val  = gap_sel;
            state_d  = S_GAP;
          end
        end
      end
      S_GAP: begin
        if (tmr_expired) begin
          cnt_dec = 1'b1;
          if (cnt_last) state_d = S_READY;
          else begin
            tmr_load = 1'b1;
            tmr_val  = pw_sel;
            state_d  = S_PULSE;
          end
        end
      end
      S_READY: begin
        if (rdy_ack) begin
          if (!rdy_ok) begin
            stat_d  = STAT_RDY_ERR;
            state_d = S_DONE;
          end else if (recal_q) begin
            state_d = S_TRK;
          end else begin
            stat_d  = STAT_OK;
            state_d = S_DONE;
          end
        end
      end
      S_TRK: begin
        if (!trk0_n) begin
          stat_d  = STAT_OK;
          state_d = S_DONE;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = pw_sel;
          state_d  = S_PULSE;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      stat_q  <= STAT_NONE;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_n_q <= 1'b1;
      slow_q  <= 1'b0;
      recal_q <= 1'b0;
    end else if (accept) begin
      dir_n_q <= ~(cmd_recal | ofs_neg);
      slow_q  <= cmd_slow | cmd_recal;
      recal_q <= cmd_recal;
    end
  end

  assign step_o      = (state_q == S_PULSE);
  assign rdy_req     = (state_q == S_READY);
  assign done        = (state_q == S_DONE);
  assign busy        = (state_q != S_IDLE);
  assign dir_n_o     = dir_n_q;
  assign done_status = stat_q;

endmodule

// File: rtl/head_step_seq.sv
module head_step_seq #(
  parameter int OFS_W    = 16,
  parameter int FAST_PW  = 1000,
  parameter int FAST_GAP = 6000,
  parameter int SLOW_PW  = 8000,
  parameter int SLOW_GAP = 800000,
  parameter int SETTLE   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_recal,
  input  logic             cmd_slow,
  input  logic [OFS_W-1:0] cmd_offset,
  input  logic             rdy_ack,
  input  logic             rdy_ok,
  input  logic             trk0_n,
  output logic             step_o,
  output logic             dir_n_o,
  output logic             rdy_req,
  output logic             busy,
  output logic             done,
  output logic [1:0]       done_status
);

  localparam int MAX_A  = (FAST_PW > FAST_GAP) ? FAST_PW : FAST_GAP;
  localparam int MAX_B  = (SLOW_PW > SLOW_GAP) ? SLOW_PW : SLOW_GAP;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int T_MAX  = (MAX_C > SETTLE) ? MAX_C : SETTLE;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam int PW_MIN = (FAST_PW < SLOW_PW) ? FAST_PW : SLOW_PW;

  logic             rst_meta, rst_sync_n;
  logic             cnt_load, cnt_dec, cnt_zero, cnt_last;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  stepseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  stepseq_stepcnt #(.OFS_W(OFS_W)) u_stepcnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (cnt_load),
    .offset  (cmd_offset),
    .dec     (cnt_dec),
    .is_zero (cnt_zero),
    .is_last (cnt_last)
  );

  stepseq_fsm #(
    .CNT_W    (CNT_W),
    .FAST_PW  (FAST_PW),
    .FAST_GAP (FAST_GAP),
    .SLOW_PW  (SLOW_PW),
    .SLOW_GAP (SLOW_GAP),
    .SETTLE   (SETTLE)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_valid   (cmd_valid),
    .cmd_recal   (cmd_recal),
    .cmd_slow    (cmd_slow),
    .ofs_neg     (cmd_offset[OFS_W-1]),
    .cnt_zero    (cnt_zero),
    .cnt_last    (cnt_last),
    .tmr_expired (tmr_expired),
    .rdy_ack     (rdy_ack),
    .rdy_ok      (rdy_ok),
    .trk0_n      (trk0_n),
    .cnt_load    (cnt_load),
    .cnt_dec     (cnt_dec),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .step_o      (step_o),
    .dir_n_o     (dir_n_o),
    .rdy_req     (rdy_req),
    .busy        (busy),
    .done        (done),
    .done_status (done_status)
  );

endmodule

// File: rtl/stepseq_checker.sv
module stepseq_checker #(
  parameter int PW_MIN = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       step_o,
  input logic       dir_n_o,
  input logic       rdy_req,
  input logic       rdy_ack,
  input logic       busy,
  input logic       done,
  input logic [1:0] done_status
);

  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (step_o) hi_cnt <= hi_cnt + 32'd1;
    else             hi_cnt <= '0;
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!step_o && !rdy_req && !done));

  a_r3_dir_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> $stable(dir_n_o));

  a_r6_min_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(step_o) |-> (hi_cnt >= 32'(PW_MIN)));

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_req && !rdy_ack) |=> rdy_req);

  a_r8_no_step_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_req |-> !step_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r9_status_posted: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_status == 2'b01 || done_status == 2'b10));

endmodule

bind head_step_seq stepseq_checker #(.PW_MIN(PW_MIN)) u_stepseq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_o      (step_o),
  .dir_n_o     (dir_n_o),
  .rdy_req     (rdy_req),
  .rdy_ack     (rdy_ack),
  .busy        (busy),
  .done        (done),
  .done_status (done_status)
);

// File: tb/test_head_step_seq.sv
`timescale 1ns/1ps
module test_head_step_seq;

  localparam int OFS_W    = 8;
  localparam int FAST_PW  = 3;
  localparam int FAST_GAP = 5;
  localparam int SLOW_PW  = 6;
  localparam int SLOW_GAP = 11;
  localparam int SETTLE   = 4;

  logic clk, rst_n;
  logic cmd_valid, cmd_recal, cmd_slow;
  logic [OFS_W-1:0] cmd_offset;
  logic rdy_ack, rdy_ok, trk0_n;
  logic step_o, dir_n_o, rdy_req, busy, done;
  logic [1:0] done_status;

  int checks, errors;
  int pos;
  int mon_on;
  int n_pulse, n_req, lo_run, hi_run, settle_m, tail_m;
  int w_min, w_max, g_min, g_max, dir_bad;
  logic step_p, rdy_p;
  int req_idx, fail_idx, rsp_dly;

  head_step_seq #(
    .OFS_W(OFS_W), .FAST_PW(FAST_PW), .FAST_GAP(FAST_GAP),
    .SLOW_PW(SLOW_PW), .SLOW_GAP(SLOW_GAP), .SETTLE(SETTLE)
  ) i_head_step_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_recal(cmd_recal),
    .cmd_slow(cmd_slow), .cmd_offset(cmd_offset), .rdy_ack(rdy_ack),
    .rdy_ok(rdy_ok), .trk0_n(trk0_n), .step_o(step_o), .dir_n_o(dir_n_o),
    .rdy_req(rdy_req), .busy(busy), .done(done), .done_status(done_status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign trk0_n = (pos != 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor of step and request timing, sampled at the falling edge.
  always @(negedge clk) begin
    if (step_o && !step_p && !dir_n_o && pos > 0) pos = pos - 1;
    if (mon_on != 0) begin
      if (step_o && !step_p) begin
        if (n_pulse == 0) settle_m = lo_run;
        else begin
          if (lo_run < g_min) g_min = lo_run;
          if (lo_run > g_max) g_max = lo_run;
        end
        n_pulse++;
        lo_run = 0;
        hi_run = 0;
      end
      if (!step_o && step_p) begin
        if (hi_run < w_min) w_min = hi_run;
        if (hi_run > w_max) w_max = hi_run;
        hi_run = 0;
        lo_run = 0;
      end
      if (rdy_req && !rdy_p) begin
        if (n_req == 0) tail_m = lo_run;
        n_req++;
      end
      if (step_o) hi_run++; else lo_run++;
    end
    step_p = step_o;
    rdy_p  = rdy_req;
  end

  // Ready qualifier model.
  initial begin
    rdy_ack = 1'b0;
    rdy_ok  = 1'b0;
    rsp_dly = 0;
    forever begin
      @(negedge clk); #1;
      if (rdy_ack) rdy_ack = 1'b0;
      else if (rdy_req) begin
        if (rsp_dly == 0) begin
          rdy_ack = 1'b1;
          rdy_ok  = (req_idx != fail_idx);
          req_idx++;
          rsp_dly = int'($urandom % 3);
        end else rsp_dly--;
      end
    end
  end

  task automatic run_cmd(input bit recal, input bit slow, input int off,
                         input int fidx, input bit inject);
    int mag, exp_p, exp_req, exp_stat, pw, gap, guard;
    bit exp_dir;
    @(negedge clk); #1;
    n_pulse = 0; n_req = 0; lo_run = 0; hi_run = 0; settle_m = -1; tail_m = -1;
    w_min = 1 << 30; w_max = 0; g_min = 1 << 30; g_max = 0; dir_bad = 0;
    req_idx = 0; fail_idx = fidx;
    mag = (off < 0) ? -off : off;
    cmd_valid = 1'b1; cmd_recal = recal; cmd_slow = slow;
    cmd_offset = OFS_W'(off);
    mon_on = 1;
    if (recal) begin
      exp_p   = (fidx < 0 || fidx >= pos) ? pos : fidx + 1;
      exp_req = exp_p;
      exp_dir = 1'b0;
      pw = SLOW_PW; gap = SLOW_GAP;
    end else begin
      exp_p   = mag;
      exp_req = 1;
      exp_dir = (off < 0) ? 1'b0 : 1'b1;
      pw  = slow ? SLOW_PW : FAST_PW;
      gap = slow ? SLOW_GAP : FAST_GAP;
    end
    exp_stat = (fidx >= 0 && fidx < exp_req) ? 2 : 1;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    if (inject) begin
      @(negedge clk); #1;
      cmd_valid = 1'b1; cmd_recal = 1'b1; cmd_offset = OFS_W'(-5);
      @(negedge clk); #1;
      cmd_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin
      if (step_o && dir_n_o != exp_dir) dir_bad = 1;
      @(negedge clk); #1;
      guard++;
    end
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    chk(int'(done_status) == exp_stat, recal ? "R11 status" : "R9 status",
        int'(done_status), exp_stat);
    chk(n_pulse == exp_p, recal ? "R10 pulse count" : "R5 pulse count", n_pulse, exp_p);
    chk(n_req == exp_req, "R8 request count", n_req, exp_req);
    chk(dir_bad == 0 && dir_n_o == exp_dir, "R3 direction", int'(dir_n_o), int'(exp_dir));
    if (exp_p > 0) begin
      chk(w_min == pw && w_max == pw, slow || recal ? "R7 width" : "R6 width", w_max, pw);
      if (!recal) chk(settle_m == SETTLE, "R4 settle", settle_m, SETTLE);
    end
    if (exp_p > 1 && !recal)
      chk(g_min == gap && g_max == gap, slow ? "R7 gap" : "R6 gap", g_max, gap);
    if (!recal) begin
      chk(tail_m == ((mag == 0) ? SETTLE : gap), "R8 trailing gap", tail_m,
          (mag == 0) ? SETTLE : gap);
    end
    @(negedge clk); #1;
    mon_on = 0;
    chk(!busy && !done, "R9 busy falls after done", int'(busy), 0);
  endtask

  initial begin
    int off;
    checks = 0; errors = 0; pos = 0; mon_on = 0;
    step_p = 1'b0; rdy_p = 1'b0; req_idx = 0; fail_idx = -1;
    cmd_valid = 1'b0; cmd_recal = 1'b0; cmd_slow = 1'b0; cmd_offset = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !step_o && !rdy_req && !done && dir_n_o && done_status == 2'b00,
        "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !step_o && !rdy_req && dir_n_o && done_status == 2'b00,
        "R1 idle after release", int'(dir_n_o), 1);

    run_cmd(1'b0, 1'b0, 0, -1, 1'b0);      // R5 zero offset
    run_cmd(1'b0, 1'b0, 3, -1, 1'b0);      // R6 fast outward
    run_cmd(1'b0, 1'b1, -3, -1, 1'b0);     // R7 slow inward
    run_cmd(1'b0, 1'b0, -128, -1, 1'b0);   // R5 most negative
    run_cmd(1'b0, 1'b0, 127, -1, 1'b0);    // R5 most positive
    run_cmd(1'b0, 1'b0, 2, 0, 1'b0);       // R9 ready error
    run_cmd(1'b0, 1'b0, 2, -1, 1'b1);      // R2 ignored while busy
    pos = 3;
    run_cmd(1'b1, 1'b0, 0, -1, 1'b0);      // R10 three steps home
    pos = 0;
    run_cmd(1'b1, 1'b0, 0, -1, 1'b0);      // R10 already home
    pos = 4;
    run_cmd(1'b1, 1'b0, 0, 1, 1'b0);       // R11 abort on second check
    pos = 0;

    for (int i = 0; i < 24; i++) begin
      off = int'($urandom % 13) - 6;
      run_cmd(1'b0, ($urandom % 4) == 0, off, (($urandom % 5) == 0) ? 0 : -1, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule